// File: doc/BRIEF.md
# Transmit Word Buffer with Release Gating

This block holds up to 32 words of 32 bits that wait for an ARINC 429 word serializer. The host side is reduced to already-decoded command pulses. A load strobe writes one word per cycle, so a burst of strobes fills consecutive free slots. A load-end pulse marks the end of a burst. A clear pulse discards everything. A send pulse starts transmission. The serializer side sees the oldest stored word and an available flag, and takes one word at a time with a pop strobe.

Whether a word may leave the buffer is decided by one release flag. In auto mode the flag opens when a burst ends. In trigger mode only the send pulse opens it. Once open, it stays open until the buffer has drained and the serializer reports that its last word is finished. Words loaded while it is open are therefore sent in the same run. Words loaded after it closes wait for the next opening. Empty, half-full and full flags let the host size its block writes.

Top module: `tx_word_buffer`

## Requirements
- R1: After reset the buffer holds no words. empty_o=1, half_o=0, full_o=0, release_o=0 and avail_o=0.
- R2: Words leave in the order they were loaded. While the buffer holds at least one word, rd_data_o shows the oldest one, and each accepted pop moves on to the next.
- R3: A load strobe that arrives while all 32 slots are occupied is dropped. full_o stays 1 and the stored words are unchanged. full_o=1 exactly when 32 words are held.
- R4: empty_o=1 exactly when no word is held. half_o=0 while fewer than 16 words are held and 1 from 16 words upward.
- R5: A clear pulse empties the buffer and closes the release on the next edge. It wins over a load or a pop in the same cycle, and neither of those has any effect.
- R6: With auto_send_i=1, a load-end pulse opens the release on the next edge.
- R7: With auto_send_i=0, stored words stay held (avail_o=0) and load-end has no effect on the release. Only a send pulse opens it, and it does so on the next edge.
- R8: avail_o=1 exactly when the release is open and the buffer is not empty. An open release stays open while words remain, so words loaded during a run are also sent.
- R9: The release closes on the edge after a cycle in which the buffer is empty, no word is loaded, no open request is present and word_done_i=1. Words loaded after that stay held.
- R10: A load and an accepted pop in the same cycle leave the word count unchanged. The popped word is the old head and the new word goes to the tail.
- R11: A pop strobe while avail_o=0 is ignored, and the head word and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Load one word this cycle |
| wr_data_i | input | 32 | Word to load |
| load_end_i | input | 1 | Pulse marking the end of a load burst |
| clear_i | input | 1 | Pulse that discards all stored words |
| send_i | input | 1 | Send-trigger pulse |
| auto_send_i | input | 1 | Mode: 1 sends after each burst, 0 waits for send_i |
| pop_i | input | 1 | Serializer takes the head word |
| word_done_i | input | 1 | Serializer has finished shifting its last word |
| rd_data_o | output | 32 | Oldest stored word |
| avail_o | output | 1 | A word may be popped |
| release_o | output | 1 | Release flag |
| empty_o | output | 1 | No word held |
| half_o | output | 1 | 16 or more words held |
| full_o | output | 1 | All 32 slots held |

## Verification
The bench builds the block with its default parameters: 32-bit words, 32 slots, and the half mark at 16. At these values a single 34-strobe burst reaches the full boundary and shows the two dropped words. The half flag crosses at the same count the host relies on. With a power-of-two depth, the read and write pointers wrap several times during a long run of simultaneous loads and pops, so wraparound is also covered.

// File: rtl/tx_buf_pkg.sv
package tx_buf_pkg;
  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } buf_op_t;
endpackage

// File: rtl/tx_buf_store.sv
module tx_buf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // head word falls through without a read cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tx_buf_ctrl.sv
module tx_buf_ctrl
  import tx_buf_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HALF_MARK = DEPTH / 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  buf_op_t          op_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             empty_o,
  output logic             half_o,
  output logic             full_o
);
  logic [PTR_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [CNT_W-1:0] count_q;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + PTR_W'(1);
      assign rd_nxt = rd_q + PTR_W'(1);
    end else begin : g_mod
      assign wr_nxt = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
      assign rd_nxt = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else if (op_i.clear) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (op_i.push) wr_q <= wr_nxt;
      if (op_i.pop)  rd_q <= rd_nxt;
      case ({op_i.push, op_i.pop})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CNT_W'(DEPTH));
  assign half_o   = (count_q >= CNT_W'(HALF_MARK));

  // R4
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R5
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.clear |=> empty_o && (wr_ptr_o == rd_ptr_o));
  // R10
  push_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i.push && op_i.pop && !op_i.clear |=> $stable(count_q));
  // R4
  pointer_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o || full_o) |-> (wr_ptr_o == rd_ptr_o));
endmodule

// File: rtl/tx_buf_release.sv
module tx_buf_release (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic send_i,
  input  logic load_end_i,
  input  logic auto_send_i,
  input  logic push_i,
  input  logic empty_i,
  input  logic word_done_i,
  output logic release_o
);
  logic rel_q, open_req, close_req;

  assign open_req  = send_i || (load_end_i && auto_send_i);
  // closes only once nothing is left and nothing is arriving
  assign close_req = empty_i && !push_i && word_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rel_q <= 1'b0;
    else if (clear_i)   rel_q <= 1'b0;
    else if (open_req)  rel_q <= 1'b1;
    else if (close_req) rel_q <= 1'b0;
  end

  assign release_o = rel_q;

  // R7
  send_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_i && !clear_i |=> release_o);
  // R6
  auto_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_end_i && auto_send_i && !clear_i |=> release_o);
  // R9
  close_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(release_o) |-> $past(clear_i) || ($past(word_done_i) && $past(empty_i)));
  // R8
  hold_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o && !empty_i && !clear_i |=> release_o);
endmodule

// File: rtl/tx_word_buffer.sv
module tx_word_buffer
  import tx_buf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 32,
  parameter int HALF_MARK = DEPTH / 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_end_i,
  input  logic              clear_i,
  input  logic              send_i,
  input  logic              auto_send_i,
  input  logic              pop_i,
  input  logic              word_done_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              avail_o,
  output logic              release_o,
  output logic              empty_o,
  output logic              half_o,
  output logic              full_o
);
  buf_op_t          op;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  // clear dominates; full drops loads; closed release drops pops
  assign op.clear = clear_i;
  assign op.push  = wr_valid_i && !full_o && !clear_i;
  assign op.pop   = pop_i && avail_o && !clear_i;
  assign avail_o  = release_o && !empty_o;

  tx_buf_ctrl #(.DEPTH(DEPTH), .HALF_MARK(HALF_MARK)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .empty_o  (empty_o),
    .half_o   (half_o),
    .full_o   (full_o)
  );

  tx_buf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (op.push),
    .waddr_i (wr_ptr),
    .wdata_i (wr_data_i),
    .raddr_i (rd_ptr),
    .rdata_o (rd_data_o)
  );

  tx_buf_release u_rel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .send_i      (send_i),
    .load_end_i  (load_end_i),
    .auto_send_i (auto_send_i),
    .push_i      (op.push),
    .empty_i     (empty_o),
    .word_done_i (word_done_i),
    .release_o   (release_o)
  );

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_valid_i && !op.pop && !clear_i |=> full_o && $stable(rd_data_o));
  // R11
  closed_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !avail_o && !wr_valid_i && !clear_i |=> $stable(rd_data_o) && $stable(empty_o));
  // R4
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o) && !(empty_o && half_o));
endmodule

// File: tb/tb_tx_word_buffer.sv
module tb_tx_word_buffer;
  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, load_end = 0, clr = 0, send = 0, auto_send = 0, pop = 0, done = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic avail, rel_o, empty, half, full;

  always #4 clk = ~clk;

  tx_word_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .HALF_MARK(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .load_end_i(load_end), .clear_i(clr), .send_i(send), .auto_send_i(auto_send),
    .pop_i(pop), .word_done_i(done), .rd_data_o(rd_data), .avail_o(avail),
    .release_o(rel_o), .empty_o(empty), .half_o(half), .full_o(full)
  );

  logic [DW-1:0] q[$];
  bit m_rel = 0;
  int vectors = 0, fails = 0, cycles = 0;
  string tag = "R1";

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int n = q.size();
    chk("empty", DW'(empty), DW'(n == 0));
    chk("full",  DW'(full),  DW'(n == DEPTH));
    chk("half",  DW'(half),  DW'(n >= HALF));
    chk("release", DW'(rel_o), DW'(m_rel));
    chk("avail", DW'(avail), DW'(m_rel && n > 0));
    if (n > 0) chk("head", rd_data, q[0]);
  endtask

  task automatic model(bit w, logic [DW-1:0] d, bit le, bit cl, bit sd, bit pp, bit dn);
    int n = q.size();
    bit psh = w && (n < DEPTH);
    bit ppk = pp && m_rel && (n > 0);
    if (cl) begin
      q.delete();
      m_rel = 0;
    end else begin
      if (ppk) void'(q.pop_front());
      if (psh) q.push_back(d);
      if (sd || (le && auto_send)) m_rel = 1;
      else if (n == 0 && !psh && dn) m_rel = 0;
    end
  endtask

  task automatic cyc(bit w, logic [DW-1:0] d, bit le, bit cl, bit sd, bit pp, bit dn);
    @(negedge clk);
    wr_valid = w; wr_data = d; load_end = le; clr = cl; send = sd; pop = pp; done = dn;
    @(posedge clk);
    model(w, d, le, cl, sd, pp, dn);
    #2;
    compare();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) cyc(0, '0, 0, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #20;
    tag = "R1";
    compare();
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R7: trigger mode holds, load_end ignored
    tag = "R7";
    auto_send = 0;
    for (int i = 0; i < 5; i++) cyc(1, 32'hA000_0000 + i, i == 4, 0, 0, 0, 0);
    idle(3);
    cyc(0, '0, 0, 0, 0, 1, 0);  // R11 pop while held
    tag = "R2";
    cyc(0, '0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, '0, 0, 0, 0, 1, 0);
    tag = "R9";
    idle(2);
    cyc(0, '0, 0, 0, 0, 0, 1);
    cyc(1, 32'hB000_0001, 1, 0, 0, 0, 0);
    cyc(1, 32'hB000_0002, 0, 0, 0, 0, 0);
    idle(2);
    cyc(0, '0, 0, 1, 0, 0, 0);

    // R3 / R4: overfill with 34 strobes
    tag = "R3";
    for (int i = 0; i < 34; i++) cyc(1, 32'hC000_0000 + i, 0, 0, 0, 0, 0);
    tag = "R11";
    cyc(0, '0, 0, 0, 0, 1, 0);
    // R5: clear with simultaneous load and pop while released
    tag = "R5";
    cyc(0, '0, 0, 0, 1, 0, 0);
    cyc(1, 32'hDEAD_0000, 0, 1, 0, 1, 0);
    idle(1);

    // R6: auto mode
    tag = "R6";
    auto_send = 1;
    for (int i = 0; i < 3; i++) cyc(1, 32'hE000_0000 + i, i == 2, 0, 0, 0, 0);
    // R10: load and pop together, across pointer wrap
    tag = "R10";
    for (int i = 0; i < 70; i++) cyc(1, 32'hF000_0000 + i, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, '0, 0, 0, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 0, 1);

    // R8: loads during a triggered run are sent
    tag = "R8";
    auto_send = 0;
    for (int i = 0; i < 4; i++) cyc(1, 32'h1100_0000 + i, 0, 0, 0, 0, 0);
    cyc(0, '0, 0, 0, 1, 0, 0);
    cyc(0, '0, 0, 0, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(1, 32'h2200_0000 + i, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, '0, 0, 0, 0, 1, 0);
    cyc(1, 32'h3300_0000, 0, 0, 0, 0, 1);  // load with done keeps it open
    cyc(0, '0, 0, 0, 0, 1, 0);
    tag = "R9";
    cyc(0, '0, 0, 0, 0, 0, 1);
    cyc(1, 32'h4400_0000, 0, 0, 0, 0, 0);
    idle(2);

    // R5: clear during transmission
    tag = "R5";
    for (int i = 0; i < 20; i++) cyc(1, 32'h5500_0000 + i, 0, 0, 0, 0, 0);
    tag = "R4";
    cyc(0, '0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, '0, 0, 0, 0, 1, 0);
    tag = "R5";
    cyc(0, '0, 0, 1, 0, 1, 0);
    cyc(1, 32'h6600_0000, 0, 0, 0, 0, 0);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule